// File: doc/BRIEF.md
# Opcode-Dispatch Sequencer

This block is the control state machine of an 8-bit microprocessor core. It waits in an opcode-fetch state. When the fetched opcode byte is on the data bus, it branches to the first state of the matching addressing-mode sequence. It then steps through that sequence without looking at the bus again, and finally returns to the fetch state for the next opcode.

The state register uses a mixed encoding. Twelve states can follow the fetch state, counting the fetch state itself for single-byte instructions. Each of these twelve "lead" states has a flop of its own, so the opcode-matching logic feeds only the flop it sets. The seventeen simpler follow-on states share one compact binary field, the "tail" code, and tail code 0 means that no follow-on state is active. Together the two parts give 29 states.

A ready input stalls the whole machine. The data bus is a plain sampled input with no handshake. Datapath, arithmetic, interrupts and per-state control strobes belong to other blocks.

Top module: `opdispatch_fsm`

## Requirements
- R1: While reset is high, and in the first cycle after it, the machine is in the fetch state: `lead_o` = 12'h001, `tail_o` = 0 and `sync_o` = 1.
- R2: Exactly one state is active in every cycle. Either exactly one bit of `lead_o` is set and `tail_o` is 0, or `lead_o` is 0 and `tail_o` is non-zero.
- R3: From the fetch state with ready high, the following opcodes select the immediate state, `lead_o` bit 1: 1010_00x0, 11x0_00x0 and xxx0_1001. The immediate state is entered only from the fetch state, and it returns to fetch on the next ready cycle.
- R4: From the fetch state with ready high, the other opcodes select these `lead_o` bits:
  - bit 10 (jump): 0x20, 0x4C, 0x6C, 0x7C
  - bit 11 (stack): 0x00, 0x40, 0x60, 0x08, 0x28, 0x48, 0x68, 0x5A, 0x7A, 0xDA, 0xFA
  - bit 9 (branch): xxx1_0000 and 0x80
  - bit 6 (pre-indexed indirect): xxx0_0001
  - bit 7 (post-indexed indirect): xxx1_0001
  - bit 8 (zero-page indirect): xxx1_0010
  - bit 2 (zero page): xxx0_01xx
  - bit 3 (indexed zero page): xxx1_01xx
  - bit 4 (absolute): xxx0_11xx
  - bit 5 (indexed absolute): xxx1_11xx and xxx1_1001
- R5: An opcode that matches none of the patterns in R3 and R4 keeps the machine in the fetch state, so `lead_o` bit 0 stays set.
- R6: The data bus has no effect on the next state while the machine is outside the fetch state.
- R7: The follow-on tail codes are ZPX1=1, ABS1=2, ABX1=3, ABX2=4, IDX1..3=5..7, IDY1..3=8..10, IND1=11, IND2=12, BRA1=13, JMP1=14, STK1=15, STK2=16 and DATA=17. Each lead state advances one step per ready cycle, as follows:
  - zero page: DATA
  - indexed zero page: ZPX1, DATA
  - absolute: ABS1, DATA
  - indexed absolute: ABX1, ABX2, DATA
  - pre-indexed indirect: IDX1, IDX2, IDX3, DATA
  - post-indexed indirect: IDY1, IDY2, IDY3, DATA
  - zero-page indirect: IND1, IND2, DATA
  - branch: BRA1
  - jump: JMP1
  - stack: STK1, STK2
- R8: While `rdy_i` is low, `lead_o` and `tail_o` hold their values, in every state including the fetch state.
- R9: After the last state of every sequence, the machine re-enters the fetch state, and `sync_o` is high in exactly the cycles when `lead_o` = 12'h001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rdy_i | input | 1 | Advance enable; low stalls every state flop |
| bus_i | input | 8 | Data bus; it carries the opcode in the fetch state |
| lead_o | output | 12 | One-hot lead states; bit 0 is the fetch state |
| tail_o | output | 5 | Compact follow-on state code; 0 means none |
| sync_o | output | 1 | Opcode-fetch strobe |

## Verification
The assertions assume three things about the inputs: reset is applied at start-up, `rdy_i` and `bus_i` are known values, and both inputs are stable around the rising edge. The bench meets these by changing every input only at the falling edge. It also drives a fresh random byte on the bus in every cycle outside the fetch state, so that any leak of the bus into the follow-on logic changes the observed state. Every one of the 256 opcodes is applied once in the fetch state with ready high. Random ready stalls are spread through the sequences.

// File: rtl/opd_pkg.sv
package opd_pkg;
  localparam int OPW    = 8;
  localparam int LEAD_N = 12;
  localparam int TAIL_N = 18;
  localparam int TAIL_W = $clog2(TAIL_N);

  // lead flop positions
  localparam int L_SYNC = 0;
  localparam int L_IMM  = 1;
  localparam int L_ZP   = 2;
  localparam int L_ZPX  = 3;
  localparam int L_ABS  = 4;
  localparam int L_ABX  = 5;
  localparam int L_IDX  = 6;
  localparam int L_IDY  = 7;
  localparam int L_IND  = 8;
  localparam int L_BRA  = 9;
  localparam int L_JMP  = 10;
  localparam int L_STK  = 11;

  typedef logic [TAIL_W-1:0] tail_t;
  localparam tail_t T_NONE = tail_t'(0);
  localparam tail_t T_ZPX1 = tail_t'(1);
  localparam tail_t T_ABS1 = tail_t'(2);
  localparam tail_t T_ABX1 = tail_t'(3);
  localparam tail_t T_ABX2 = tail_t'(4);
  localparam tail_t T_IDX1 = tail_t'(5);
  localparam tail_t T_IDX2 = tail_t'(6);
  localparam tail_t T_IDX3 = tail_t'(7);
  localparam tail_t T_IDY1 = tail_t'(8);
  localparam tail_t T_IDY2 = tail_t'(9);
  localparam tail_t T_IDY3 = tail_t'(10);
  localparam tail_t T_IND1 = tail_t'(11);
  localparam tail_t T_IND2 = tail_t'(12);
  localparam tail_t T_BRA1 = tail_t'(13);
  localparam tail_t T_JMP1 = tail_t'(14);
  localparam tail_t T_STK1 = tail_t'(15);
  localparam tail_t T_STK2 = tail_t'(16);
  localparam tail_t T_DATA = tail_t'(17);
endpackage

// File: rtl/opd_decode.sv
module opd_decode
  import opd_pkg::*;
(
  input  logic [OPW-1:0]    op,
  output logic [LEAD_N-1:0] sel
);
  logic jmp, stk, bra, imm, idx, idy, ind, zp, zpx, absm, abx;

  always_comb begin
    jmp  = (op == 8'h20) || (op == 8'h4C) || (op == 8'h6C) || (op == 8'h7C);
    stk  = (!op[7] && op[4:0] == 5'b00000 && op != 8'h20)
         || (!op[7] && op[4:0] == 5'b01000)
         || (op[6] && op[4] && op[3:0] == 4'hA);
    bra  = (op[4:0] == 5'b10000) || (op == 8'h80);
    // immediate operand: three opcode families
    imm  = (op[7:2] == 6'b101000 && !op[0])
         || (op[7:6] == 2'b11 && !op[4] && op[3:2] == 2'b00 && !op[0])
         || (op[4:0] == 5'b01001);
    idx  = (op[4:0] == 5'b00001);
    idy  = (op[4:0] == 5'b10001);
    ind  = (op[4:0] == 5'b10010);
    zp   = (op[4:2] == 3'b001);
    zpx  = (op[4:2] == 3'b101);
    absm = (op[4:2] == 3'b011) && !jmp;
    abx  = ((op[4:2] == 3'b111) && !jmp) || (op[4:0] == 5'b11001);

    sel         = '0;
    sel[L_JMP]  = jmp;
    sel[L_STK]  = stk;
    sel[L_BRA]  = bra;
    sel[L_IMM]  = imm;
    sel[L_IDX]  = idx;
    sel[L_IDY]  = idy;
    sel[L_IND]  = ind;
    sel[L_ZP]   = zp;
    sel[L_ZPX]  = zpx;
    sel[L_ABS]  = absm;
    sel[L_ABX]  = abx;
    sel[L_SYNC] = !(jmp | stk | bra | imm | idx | idy | ind | zp | zpx | absm | abx);
  end
endmodule

// File: rtl/opd_lead.sv
module opd_lead
  import opd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rdy,
  input  logic [LEAD_N-1:0] sel,
  input  logic              done,
  output logic [LEAD_N-1:0] q
);
  localparam logic [LEAD_N-1:0] RST_VAL = LEAD_N'(1) << L_SYNC;

  logic [LEAD_N-1:0] nxt;

  // one flop per fetch successor; only the fetch flop also sees sequence end
  for (genvar i = 0; i < LEAD_N; i++) begin : g_bit
    if (i == L_SYNC) begin : g_sync
      assign nxt[i] = q[L_SYNC] ? sel[i] : done;
    end else begin : g_succ
      assign nxt[i] = q[L_SYNC] & sel[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= RST_VAL;
    else if (rdy) q <= nxt;
  end

  assert_lead_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rdy |=> $stable(q));

  assert_imm_from_sync_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(q[L_IMM]) |-> $past(q[L_SYNC]));
endmodule

// File: rtl/opd_tail.sv
module opd_tail
  import opd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rdy,
  input  logic [LEAD_N-1:0] lead,
  output tail_t             q,
  output logic              done
);
  function automatic tail_t entry_code(int idx);
    case (idx)
      L_ZP:    return T_DATA;
      L_ZPX:   return T_ZPX1;
      L_ABS:   return T_ABS1;
      L_ABX:   return T_ABX1;
      L_IDX:   return T_IDX1;
      L_IDY:   return T_IDY1;
      L_IND:   return T_IND1;
      L_BRA:   return T_BRA1;
      L_JMP:   return T_JMP1;
      L_STK:   return T_STK1;
      default: return T_NONE;
    endcase
  endfunction

  function automatic tail_t step_code(tail_t c);
    case (c)
      T_ZPX1, T_ABS1, T_ABX2, T_IDX3, T_IDY3, T_IND2: return T_DATA;
      T_ABX1:  return T_ABX2;
      T_IDX1:  return T_IDX2;
      T_IDX2:  return T_IDX3;
      T_IDY1:  return T_IDY2;
      T_IDY2:  return T_IDY3;
      T_IND1:  return T_IND2;
      T_STK1:  return T_STK2;
      default: return T_NONE;
    endcase
  endfunction

  tail_t nxt, entry, stepped;

  always_comb begin
    entry = T_NONE;
    for (int i = 1; i < LEAD_N; i++)
      if (lead[i]) entry = entry | entry_code(i);
    stepped = step_code(q);
    if (lead[L_SYNC])  nxt = T_NONE;
    else if (|lead)    nxt = entry;
    else               nxt = stepped;
    done = lead[L_IMM] | ((q != T_NONE) && (stepped == T_NONE));
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= T_NONE;
    else if (rdy) q <= nxt;
  end

  assert_tail_legal_R7: assert property (@(posedge clk) disable iff (rst)
    q < tail_t'(TAIL_N));

  assert_tail_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rdy |=> $stable(q));
endmodule

// File: rtl/opdispatch_fsm.sv
module opdispatch_fsm
  import opd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rdy_i,
  input  logic [OPW-1:0]    bus_i,
  output logic [LEAD_N-1:0] lead_o,
  output logic [TAIL_W-1:0] tail_o,
  output logic              sync_o
);
  logic [LEAD_N-1:0] sel;
  logic [LEAD_N-1:0] lead_q;
  tail_t             tail_q;
  logic              done;

  opd_decode u_decode (.op(bus_i), .sel(sel));

  assert_decode_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    lead_q[L_SYNC] |-> $onehot(sel));

  opd_lead u_lead (
    .clk(clk), .rst(rst), .rdy(rdy_i), .sel(sel), .done(done), .q(lead_q)
  );

  opd_tail u_tail (
    .clk(clk), .rst(rst), .rdy(rdy_i), .lead(lead_q), .q(tail_q), .done(done)
  );

  assign lead_o = lead_q;
  assign tail_o = tail_q;
  assign sync_o = lead_q[L_SYNC];

  assert_one_state_R2: assert property (@(posedge clk) disable iff (rst)
    ($countones(lead_q) + ((tail_q != T_NONE) ? 1 : 0)) == 1);

  assert_data_returns_R9: assert property (@(posedge clk) disable iff (rst)
    (tail_q == T_DATA && rdy_i) |=> (lead_q[L_SYNC] && tail_q == T_NONE));

  assert_reset_state_R1: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (lead_q == (LEAD_N'(1) << L_SYNC) && tail_q == T_NONE));
endmodule

// File: tb/opdispatch_fsm_tb.sv
module opdispatch_fsm_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rdy = 1'b0;
  logic [7:0]  db  = 8'h00;
  logic [11:0] lead;
  logic [4:0]  tail;
  logic        sync;

  always #4 clk = ~clk;

  opdispatch_fsm u_dut (
    .clk(clk), .rst(rst), .rdy_i(rdy), .bus_i(db),
    .lead_o(lead), .tail_o(tail), .sync_o(sync)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int m_cls = 0;
  int m_k = -1;   // -1: fetch state, 0: lead state, >=1: tail step

  // class numbers equal the lead bit positions of R3/R4; 0 = stays in fetch
  function automatic int classify(logic [7:0] op);
    int r = int'(op[7:4]);
    int c = int'(op[3:0]);
    if (op == 8'h20 || op == 8'h4C || op == 8'h6C || op == 8'h7C) return 10;
    case (c)
      0: begin
        if (r % 2 == 1 || op == 8'h80) return 9;
        if (op == 8'h00 || op == 8'h40 || op == 8'h60) return 11;
        if (op == 8'hA0 || op == 8'hC0 || op == 8'hE0) return 1;
        return 0;
      end
      1: return (r % 2 == 1) ? 7 : 6;
      2: begin
        if (r % 2 == 1) return 8;
        if (op == 8'hA2 || op == 8'hC2 || op == 8'hE2) return 1;
        return 0;
      end
      4, 5, 6, 7: return (r % 2 == 1) ? 3 : 2;
      8: return (r < 8 && r % 2 == 0) ? 11 : 0;
      9: return (r % 2 == 1) ? 5 : 1;
      10: return (op == 8'h5A || op == 8'h7A || op == 8'hDA || op == 8'hFA) ? 11 : 0;
      12, 13, 14, 15: return (r % 2 == 1) ? 5 : 4;
      default: return 0;
    endcase
  endfunction

  function automatic int tail_len(int cls);
    case (cls)
      2: return 1;  3: return 2;  4: return 2;  5: return 3;
      6: return 4;  7: return 4;  8: return 3;  9: return 1;
      10: return 1; 11: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic logic [4:0] tail_code(int cls, int k);
    if (k == tail_len(cls) && cls >= 2 && cls <= 8) return 5'd17;  // DATA
    case (cls)
      3: return 5'd1;
      4: return 5'd2;
      5: return 5'(2 + k);
      6: return 5'(4 + k);
      7: return 5'(7 + k);
      8: return 5'(10 + k);
      9: return 5'd13;
      10: return 5'd14;
      11: return 5'(14 + k);
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [11:0] exp_lead();
    if (m_k < 0) return 12'h001;
    if (m_k == 0) return 12'h001 << m_cls;
    return 12'h000;
  endfunction

  function automatic logic [4:0] exp_tail();
    if (m_k >= 1) return tail_code(m_cls, m_k);
    return 5'd0;
  endfunction

  task automatic check(string tag);
    logic [11:0] el = exp_lead();
    logic [4:0]  et = exp_tail();
    int act_n;
    checks++;
    if (lead !== el || tail !== et) begin
      errors++;
      $display("FAIL %s state: lead=%h tail=%0d expected lead=%h tail=%0d", tag, lead, tail, el, et);
    end
    checks++;
    if (sync !== (el == 12'h001)) begin
      errors++;
      $display("FAIL R9 sync_o=%b expected %b", sync, (el == 12'h001));
    end
    checks++;
    act_n = $countones(lead) + ((tail != 5'd0) ? 1 : 0);
    if (act_n != 1) begin
      errors++;
      $display("FAIL R2 active states=%0d expected 1", act_n);
    end
  endtask

  task automatic cycle(bit r, logic [7:0] d);
    string tag;
    int cls;
    if (!r) tag = "R8";
    else if (m_k < 0) begin
      cls = classify(d);
      tag = (cls == 1) ? "R3" : (cls == 0) ? "R5" : "R4";
    end else tag = "R7/R6";
    rdy = r;
    db  = d;
    if (r) begin
      if (m_k < 0) begin
        m_cls = classify(d);
        m_k   = (m_cls == 0) ? -1 : 0;
      end else if (m_k < tail_len(m_cls)) m_k++;
      else m_k = -1;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    void'($urandom(32'h5EED_0C0D));
    @(negedge clk);
    @(negedge clk);
    check("R1");
    rst = 1'b0;
    cycle(1'b1, 8'hEA);  // first cycle out of reset: still fetch (R1, R5)

    // every opcode once; random bus and stalls inside the sequence (R6, R7, R8)
    for (int op = 0; op < 256; op++) begin
      cycle(1'b1, 8'(op));
      while (m_k >= 0) cycle(($urandom % 5) != 0, 8'($urandom));
    end

    // stall in the fetch state with an immediate opcode present (R8)
    cycle(1'b0, 8'hA2);
    cycle(1'b1, 8'hA2);     // enter immediate (R3)
    cycle(1'b0, 8'h4C);     // stall in immediate (R8)
    cycle(1'b1, 8'h4C);     // back to fetch, bus ignored (R6, R9)
    cycle(1'b1, 8'hE9);     // column 9 even row (R3)
    cycle(1'b1, 8'h00);

    // bus ignored in a long sequence: opcodes on bus that would change state (R6)
    cycle(1'b1, 8'h01);
    cycle(1'b1, 8'hA9);
    cycle(1'b1, 8'h20);
    cycle(1'b1, 8'hFF);
    cycle(1'b1, 8'h10);
    cycle(1'b1, 8'h09);

    // constrained random mix
    repeat (3000) cycle(($urandom % 4) != 0, 8'($urandom));

    // reset from the middle of a sequence (R1)
    while (m_k >= 0) cycle(1'b1, 8'($urandom));
    cycle(1'b1, 8'h11);
    cycle(1'b1, 8'h00);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    m_k = -1;
    check("R1");
    rst = 1'b0;
    cycle(1'b1, 8'h4C);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: cycles=100000 expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule